// File: doc/BRIEF.md
# Shared-Pin ROM/RAM Combo Control

This block is the select and direction logic inside a memory that holds a read-only array and a static RAM. Both arrays share one byte-wide bidirectional data bus. A ROM select pin, a dual-role pin, a write enable and a 19-bit address drive the block. The dual-role pin is the output enable while the ROM select is low. While the ROM select is high, the same pin is the RAM chip select. From these pins the block decides each cycle which array is read and whether the RAM is written. It also decides whether the data bus is driven or left floating.

The pins are sampled on a clock. A RAM write is the span of cycles in which the RAM select and the write enable are both low. The byte stored is the one on the bus in the last cycle of that span, and it is committed in the first cycle after the span ends. Both arrays are behavioural. The ROM contents are computed from the address, so no ROM storage is held. The RAM depth is a parameter, which keeps simulation small.

Top module: `combo_mem_ctrl`

## Requirements
- R1: With `rom_sel_n` high and `oe_ramsel_n` high the block is in standby: `data_oe` is 0 for either level of `we_n`, and no array enable is asserted.
- R2: With `rom_sel_n` low and `oe_ramsel_n` high the bus floats (`data_oe` = 0).
- R3: With `rom_sel_n` low and `oe_ramsel_n` low, `rom_rd_en` and `data_oe` are 1. `data_out` is the ROM byte for `addr`: `addr[7:0] ^ addr[15:8] ^ {5'b0, addr[18:16]} ^ 8'hA5`, using all 19 address bits.
- R4: With `rom_sel_n` high, `oe_ramsel_n` low and `we_n` high, `ram_rd_en` and `data_oe` are 1 and `data_out` is the RAM byte at location `addr[RAM_AW-1:0]`.
- R5: A RAM write spans the cycles in which `rom_sel_n` is high and `oe_ramsel_n` and `we_n` are both low. `ram_wr_en` pulses for exactly one cycle, the first cycle after that span ends, and never during the span.
- R6: Whichever of `we_n` or `oe_ramsel_n` falls first, `data_oe` is 0 in every cycle of the write span.
- R7: The byte stored is the `data_in` value sampled in the last cycle of the write span. Earlier bus values in the same span are discarded.
- R8: With `rom_sel_n` low, a low `we_n` writes nothing. `ram_wr_en` stays 0, RAM contents are unchanged, and the bus remains under output-enable control with ROM data.
- R9: Address bits above the RAM width (bits 15 to 18 included) do not select a RAM location. A write and a read that differ only in those bits refer to the same byte.
- R10: A RAM read of the written address in the cycle right after a write span returns the newly written byte.
- R11: A synchronous active-low `rst_n` clears any pending write, so `ram_wr_en` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_sel_n | input | 1 | ROM select, active low |
| oe_ramsel_n | input | 1 | Output enable while the ROM is selected, RAM select otherwise |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address |
| data_in | input | 8 | Bus value seen when the bus is an input |
| data_out | output | 8 | Bus value driven when `data_oe` is 1 |
| data_oe | output | 1 | Tri-state enable of the data bus |
| rom_rd_en | output | 1 | ROM array read enable |
| ram_rd_en | output | 1 | RAM array read enable |
| ram_wr_en | output | 1 | RAM array write strobe |

## Verification
The embedded assertions check the pin-level invariants on every cycle:
- the bus is released in standby, in ROM float and throughout any write span;
- at most one read enable is active;
- a write strobe only follows a write span and lasts one cycle;
- a write strobe never follows a span in which the ROM was selected.

The assertions cannot show data content. The directed scenarios are needed for that: the ROM byte pattern, RAM read-back, the store of the last bus value of the span, aliasing of the upper address bits, forwarding of a fresh write, and RAM contents left unchanged after a write attempt on the ROM side.

// File: rtl/combo_pkg.sv
// Package: shared widths, access mode encoding and the ROM content rule.
// Assumes an address of 19 bits and a byte-wide data bus.
package combo_pkg;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        MD_STANDBY   = 3'd0,
        MD_ROM_FLOAT = 3'd1,
        MD_ROM_READ  = 3'd2,
        MD_RAM_READ  = 3'd3,
        MD_RAM_WRITE = 3'd4
    } mode_e;

    // ROM byte generated from the full address, so no storage is needed.
    function automatic logic [DATA_W-1:0] rom_pattern(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
    endfunction
endpackage

// File: rtl/combo_decode.sv
// Module: combo_decode
// Turns the three control pins into one access mode. The dual-role pin is
// an output enable while the ROM is selected, and a RAM select otherwise.
// Assumes the pins are already synchronous to the clock.
module combo_decode
    import combo_pkg::*;
(
    input  logic  rom_sel_n,
    input  logic  oe_ramsel_n,
    input  logic  we_n,
    output mode_e mode
);
    // Pick the access mode; a low write enable on the ROM side stays a ROM read.
    always_comb begin
        if (!rom_sel_n)
            mode = oe_ramsel_n ? MD_ROM_FLOAT : MD_ROM_READ;
        else if (oe_ramsel_n)
            mode = MD_STANDBY;
        else
            mode = we_n ? MD_RAM_READ : MD_RAM_WRITE;
    end
endmodule

// File: rtl/combo_write_ctl.sv
// Module: combo_write_ctl
// Follows the write span (RAM select and write enable both low). On each
// cycle of the span it holds the address and bus byte. When the span ends
// it issues one write strobe carrying the last values held.
// Assumes the span is derived from sampled pins (mode == MD_RAM_WRITE).
module combo_write_ctl
    import combo_pkg::*;
#(
    parameter int RAM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_span,
    input  logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_en,
    output logic [RAM_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic span_q;

    // Track the span and keep the most recent address and byte seen within it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            span_q <= in_span;
            if (in_span) begin
                wr_addr <= ram_addr;
                wr_data <= data_in;
            end
        end
    end

    // Strobe on the first cycle after the span has ended.
    always_comb wr_en = span_q && !in_span;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                     // R5
    AST_STROBE_NOT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        in_span |-> !wr_en);                                   // R5
endmodule

// File: rtl/combo_ram.sv
// Module: combo_ram
// Behavioural byte RAM of 2**RAM_AW entries. Writes land on the clock edge.
// Reads are combinational, and a read of the location being written this
// cycle returns the new byte. Assumes one write port and one read port.
module combo_ram
    import combo_pkg::*;
#(
    parameter int RAM_AW = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RAM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the strobed byte.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read with forwarding of a write that is committing this cycle.
    always_comb rd_data = (wr_en && wr_addr == rd_addr) ? wr_data : mem[rd_addr];
endmodule

// File: rtl/combo_mem_ctrl.sv
// Module: combo_mem_ctrl (top)
// Select and bus-direction control for a combined ROM and RAM on a shared
// byte bus. Drives the array enables and the bus tri-state enable, and
// returns the byte of whichever array is being read.
// Assumes RAM_AW <= 15 and ROM_AW <= 19. Address bits above RAM_AW are
// don't-care for the RAM.
module combo_mem_ctrl
    import combo_pkg::*;
#(
    parameter int ROM_AW = 19,
    parameter int RAM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rom_sel_n,
    input  logic              oe_ramsel_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rom_rd_en,
    output logic              ram_rd_en,
    output logic              ram_wr_en
);
    mode_e             mode;
    logic [RAM_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] rom_q;
    logic [ADDR_W-1:0] rom_index;

    combo_decode u_decode (
        .rom_sel_n   (rom_sel_n),
        .oe_ramsel_n (oe_ramsel_n),
        .we_n        (we_n),
        .mode        (mode)
    );

    combo_write_ctl #(.RAM_AW(RAM_AW)) u_wctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_span  (mode == MD_RAM_WRITE),
        .ram_addr (addr[RAM_AW-1:0]),
        .data_in  (data_in),
        .wr_en    (ram_wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    combo_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk     (clk),
        .wr_en   (ram_wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr[RAM_AW-1:0]),
        .rd_data (ram_q)
    );

    // ROM depth follows ROM_AW; the index is the low address bits, zero-extended.
    generate
        if (ROM_AW >= ADDR_W) begin : g_rom_full
            always_comb rom_index = addr;
        end else begin : g_rom_part
            always_comb rom_index = {{(ADDR_W-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
        end
    endgenerate

    // Generate the ROM byte for the current index.
    always_comb rom_q = rom_pattern(rom_index);

    // Read enables and bus direction from the mode.
    always_comb begin
        rom_rd_en = (mode == MD_ROM_READ);
        ram_rd_en = (mode == MD_RAM_READ);
        data_oe   = rom_rd_en || ram_rd_en;
    end

    // Return the selected array's byte; zero while the bus is released.
    always_comb begin
        if (rom_rd_en)      data_out = rom_q;
        else if (ram_rd_en) data_out = ram_q;
        else                data_out = '0;
    end

    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_n && oe_ramsel_n) |-> !data_oe);                           // R1
    AST_ROM_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel_n && oe_ramsel_n) |-> !data_oe);                          // R2
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_n && !oe_ramsel_n && !we_n) |-> !data_oe);                 // R6
    AST_READ_ENABLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_rd_en, ram_rd_en}));                                  // R4
    AST_STROBE_AFTER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(rom_sel_n && !oe_ramsel_n && !we_n));           // R5
    AST_ROM_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> $past(rom_sel_n));                                    // R8
endmodule

// File: tb/combo_mem_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module combo_mem_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rom_sel_n, oe_ramsel_n, we_n;
    logic [18:0] addr;
    logic [7:0]  data_in;
    logic [7:0]  data_out;
    logic        data_oe, rom_rd_en, ram_rd_en, ram_wr_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    combo_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rom_sel_n(rom_sel_n), .oe_ramsel_n(oe_ramsel_n),
        .we_n(we_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .rom_rd_en(rom_rd_en), .ram_rd_en(ram_rd_en),
        .ram_wr_en(ram_wr_en)
    );

    function automatic logic [7:0] exp_rom(input logic [18:0] a);
        logic [7:0] v;
        v = a[7:0] ^ a[15:8];
        v = v ^ {5'b0, a[18:16]};
        return v ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pins(input logic rs, input logic os, input logic we);
        rom_sel_n = rs; oe_ramsel_n = os; we_n = we;
    endtask

    // RAM write; we_first picks which control falls first. Data changes mid-span.
    task automatic ram_write(input logic [18:0] a, input logic [7:0] d0,
                             input logic [7:0] d, input bit we_first);
        addr = a; pins(1, 1, 1); tick();
        if (we_first) begin
            we_n = 1'b0; tick();
            oe_ramsel_n = 1'b0;
        end else begin
            oe_ramsel_n = 1'b0; tick();
            we_n = 1'b0;
        end
        data_in = d0; #1;
        chk("R6 bus released in span", data_oe, 0);
        tick();
        chk("R5 no strobe inside span", ram_wr_en, 0);
        data_in = d; #1;
        chk("R6 bus released in span", data_oe, 0);
        tick();
        pins(1, 1, 1); data_in = 8'h00; #1;
        chk("R5 strobe after span", ram_wr_en, 1);
        tick();
        chk("R5 strobe one cycle", ram_wr_en, 0);
    endtask

    task automatic ram_read(input string req, input logic [18:0] a, input logic [7:0] exp);
        addr = a; pins(1, 0, 1); #1;
        chk({req, " ram_rd_en"}, ram_rd_en, 1);
        chk({req, " data_oe"}, data_oe, 1);
        chk({req, " data"}, data_out, exp);
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pins(1, 1, 1); addr = '0; data_in = '0;
        tick(); tick();
        rst_n = 1'b1; tick();
        chk("R11 strobe clear after reset", ram_wr_en, 0);
        chk("R1 reset bus float", data_oe, 0);
    endtask

    task automatic t_standby();
        pins(1, 1, 0); addr = 19'h12345; #1;
        chk("R1 standby we low float", data_oe, 0);
        chk("R1 standby enables", {rom_rd_en, ram_rd_en}, 0);
        tick();
        pins(1, 1, 1); #1;
        chk("R1 standby we high float", data_oe, 0);
        tick();
    endtask

    task automatic t_rom();
        logic [18:0] al [4] = '{19'h00000, 19'h7FFFF, 19'h2A5C3, 19'h51F0E};
        pins(0, 1, 1); #1;
        chk("R2 rom oe high float", data_oe, 0);
        tick();
        foreach (al[i]) begin
            addr = al[i]; pins(0, 0, 1); #1;
            chk("R3 rom_rd_en", rom_rd_en, 1);
            chk("R3 rom data", data_out, exp_rom(al[i]));
            tick();
        end
    endtask

    task automatic t_write_read();
        ram_write(19'h00005, 8'h11, 8'h3C, 1'b0);
        ram_read("R4 R7 readback", 19'h00005, 8'h3C);
        ram_write(19'h0002A, 8'h77, 8'hC9, 1'b1);
        ram_read("R4 R7 readback we first", 19'h0002A, 8'hC9);
        ram_read("R4 other location kept", 19'h00005, 8'h3C);
    endtask

    task automatic t_upper_bits();
        ram_write(19'h78011, 8'h00, 8'h5E, 1'b0);
        ram_read("R9 alias upper bits", 19'h00011, 8'h5E);
    endtask

    task automatic t_forward();
        addr = 19'h0000C; pins(1, 1, 1); tick();
        pins(1, 0, 0); data_in = 8'hB4; tick();
        we_n = 1'b1; #1;
        chk("R10 strobe with read", ram_wr_en, 1);
        chk("R10 fresh byte", data_out, 8'hB4);
        tick();
    endtask

    task automatic t_rom_write_ignored();
        addr = 19'h00005; data_in = 8'hFF; pins(0, 0, 0); #1;
        chk("R8 rom side reads", data_oe, 1);
        chk("R8 rom data", data_out, exp_rom(19'h00005));
        tick();
        chk("R8 no strobe", ram_wr_en, 0);
        tick();
        pins(0, 1, 0); #1;
        chk("R8 oe controls bus", data_oe, 0);
        tick();
        pins(1, 1, 1); #1;
        chk("R8 no strobe after", ram_wr_en, 0);
        tick();
        ram_read("R8 ram unchanged", 19'h00005, 8'h3C);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_standby();
        t_rom();
        t_write_read();
        t_upper_bits();
        t_forward();
        t_rom_write_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule